// File: doc/BRIEF.md
# Fetch Execute-Permission Checker

This block decides whether an instruction fetch may go ahead. It looks at the attributes of the page that was already translated for the fetch. For each fetch strobe it checks two things. First, the execute-permission bit that matches the current privilege level. Second, the byte order the page asks for, including a fetch that runs past the end of the page into a neighbour with a different byte order. It then either signals an instruction storage exception with a cause code or stays quiet so that the fetch proceeds. Address translation and redirection to a handler are outside this block.

The fetch side is a plain strobe with no ready. The checker never stalls, so it takes every strobe and there is no back-pressure to honour. The result appears on a registered exception strobe exactly one cycle after the fetch strobe. A higher-priority exception that is pending in the same cycle masks it. Cache-management operations that address memory travel on the data side and never drive this strobe, so they can never produce this exception.

Top module: `fxp_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `exc_vld` is 0 and `exc_cause` is 2'b00.
- R2: A fetch with `user_mode`=1 and `pg_ux`=0 raises an exception with cause 2'b01 (execute access). In user mode `pg_sx` has no effect.
- R3: A fetch with `user_mode`=0 and `pg_sx`=0 raises an exception with cause 2'b01. In supervisor mode `pg_ux` has no effect.
- R4: A fetch whose `pg_le` differs from `cfg_le` (1 = little-endian, 0 = big-endian) raises an exception with cause 2'b10 (byte order).
- R5: A fetch crosses a page when `fetch_off` > 2^PAGE_BITS − INSN_BYTES, which is 4092 with the defaults. A crossing fetch with `nxt_pg_le` ≠ `pg_le` raises cause 2'b10. When the fetch does not cross, `nxt_pg_le` has no effect.
- R6: When an execute-access fault and a byte-order fault both apply, the cause is 2'b01.
- R7: When `hi_pri_pend` is 1 in the fetch cycle, no exception is raised, whatever the attributes.
- R8: When `fetch_vld` is 0, no exception is raised, whatever the attributes. Non-fetch accesses such as cache-management operations cannot raise it.
- R9: `exc_vld`/`exc_cause` reflect the inputs sampled at the previous rising clock edge, so they are exactly one cycle late. Whenever `exc_vld` is 0, `exc_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_le | input | 1 | Byte order this implementation fetches in (1 = little) |
| fetch_vld | input | 1 | Fetch strobe, one per fetch |
| fetch_off | input | PAGE_BITS | Byte offset of the fetch address within its page |
| user_mode | input | 1 | 1 = user privilege, 0 = supervisor |
| pg_ux | input | 1 | Page allows execution in user mode |
| pg_sx | input | 1 | Page allows execution in supervisor mode |
| pg_le | input | 1 | Page byte-order attribute (1 = little) |
| nxt_pg_le | input | 1 | Byte-order attribute of the following page |
| hi_pri_pend | input | 1 | A higher-priority exception is pending this cycle |
| exc_vld | output | 1 | Instruction storage exception, one cycle after the fetch |
| exc_cause | output | 2 | 01 execute access, 10 byte order, 00 none |

## Verification
The assertions assume that every input is known and steady around the rising edge. They also assume that the page attributes and the offset belong to the fetch presented in that same cycle. The bench drives every input on the falling edge, well clear of the sampling edge. It keeps `cfg_le` fixed over stretches of many fetches, as a configuration pin would be. Between the directed corners it deliberately drives page attributes that would fault while the strobe is low, to show that the checker ignores them.

// File: rtl/fxp_pkg.sv
package fxp_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EXEC  = 2'b01,
    CAUSE_ORDER = 2'b10
  } fx_cause_e;
endpackage

// File: rtl/fxp_exec_gate.sv
// Picks the execute-permission bit that applies at the current privilege.
module fxp_exec_gate (
  input  logic user_mode,
  input  logic pg_ux,
  input  logic pg_sx,
  output logic exec_fault
);
  logic allowed;
  always_comb begin
    if (user_mode) allowed = pg_ux;
    else           allowed = pg_sx;
    exec_fault = ~allowed;
  end
endmodule

// File: rtl/fxp_order_gate.sv
// Flags an unsupported page byte order or a byte-order change across a page edge.
module fxp_order_gate #(
  parameter int PAGE_BITS  = 12,
  parameter int INSN_BYTES = 4
) (
  input  logic [PAGE_BITS-1:0] fetch_off,
  input  logic                 pg_le,
  input  logic                 nxt_pg_le,
  input  logic                 cfg_le,
  output logic                 crosses,
  output logic                 order_fault
);
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam logic [PAGE_BITS-1:0] LAST_INSIDE = PAGE_BITS'(PAGE_BYTES - INSN_BYTES);

  generate
    if (INSN_BYTES <= 1) begin : g_no_cross
      logic unused_off;
      assign unused_off = ^fetch_off;
      assign crosses    = 1'b0;
    end else begin : g_cross
      assign crosses = (fetch_off > LAST_INSIDE);
    end
  endgenerate

  logic unsupported, straddle_flip;
  always_comb begin
    unsupported   = (pg_le != cfg_le);
    straddle_flip = crosses && (nxt_pg_le != pg_le);
    order_fault   = unsupported | straddle_flip;
  end
endmodule

// File: rtl/fxp_report_reg.sv
// Priority between fault kinds, masking, and the one-cycle output register.
module fxp_report_reg
  import fxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_vld,
  input  logic       hi_pri_pend,
  input  logic       exec_fault,
  input  logic       order_fault,
  output logic       exc_vld,
  output fx_cause_e  exc_cause
);
  logic      take;
  fx_cause_e pick;

  always_comb begin
    take = fetch_vld && !hi_pri_pend && (exec_fault || order_fault);
    if (!take)           pick = CAUSE_NONE;
    else if (exec_fault) pick = CAUSE_EXEC;
    else                 pick = CAUSE_ORDER;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_vld   <= 1'b0;
      exc_cause <= CAUSE_NONE;
    end else begin
      exc_vld   <= take;
      exc_cause <= pick;
    end
  end

  a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> ($past(rst_n) && $past(fetch_vld)));
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hi_pri_pend)) |-> !exc_vld);
  a_r6_exec_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fetch_vld && !hi_pri_pend && exec_fault && order_fault))
      |-> (exc_vld && exc_cause == CAUSE_EXEC));
  a_r9_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_vld |-> (exc_cause == CAUSE_NONE));
endmodule

// File: rtl/fxp_checker.sv
module fxp_checker
  import fxp_pkg::*;
#(
  parameter int PAGE_BITS  = 12,
  parameter int INSN_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_le,
  input  logic                 fetch_vld,
  input  logic [PAGE_BITS-1:0] fetch_off,
  input  logic                 user_mode,
  input  logic                 pg_ux,
  input  logic                 pg_sx,
  input  logic                 pg_le,
  input  logic                 nxt_pg_le,
  input  logic                 hi_pri_pend,
  output logic                 exc_vld,
  output logic [1:0]           exc_cause
);
  logic      exec_fault, order_fault, crosses;
  fx_cause_e cause_q;

  fxp_exec_gate u_exec (
    .user_mode (user_mode),
    .pg_ux     (pg_ux),
    .pg_sx     (pg_sx),
    .exec_fault(exec_fault)
  );

  fxp_order_gate #(.PAGE_BITS(PAGE_BITS), .INSN_BYTES(INSN_BYTES)) u_order (
    .fetch_off  (fetch_off),
    .pg_le      (pg_le),
    .nxt_pg_le  (nxt_pg_le),
    .cfg_le     (cfg_le),
    .crosses    (crosses),
    .order_fault(order_fault)
  );

  fxp_report_reg u_rep (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_vld  (fetch_vld),
    .hi_pri_pend(hi_pri_pend),
    .exec_fault (exec_fault),
    .order_fault(order_fault),
    .exc_vld    (exc_vld),
    .exc_cause  (cause_q)
  );

  assign exc_cause = cause_q;

  a_r2_user_exec: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fetch_vld && user_mode && !pg_ux && !hi_pri_pend))
      |-> (exc_vld && exc_cause == 2'b01));
  a_r3_sup_exec: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fetch_vld && !user_mode && !pg_sx && !hi_pri_pend))
      |-> (exc_vld && exc_cause == 2'b01));
  a_r4_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fetch_vld && !hi_pri_pend && !exec_fault && pg_le != cfg_le))
      |-> (exc_vld && exc_cause == 2'b10));
  a_r5_straddle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fetch_vld && !hi_pri_pend && !exec_fault && crosses
                            && nxt_pg_le != pg_le))
      |-> (exc_vld && exc_cause == 2'b10));
endmodule

// File: tb/fxp_checker_tb_top.sv
`timescale 1ns/1ps
module fxp_checker_tb_top;
  localparam int PB = 12;
  localparam int IB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_le = 1'b1;
  logic fetch_vld = 1'b0;
  logic [PB-1:0] fetch_off = '0;
  logic user_mode = 1'b0, pg_ux = 1'b1, pg_sx = 1'b1;
  logic pg_le = 1'b1, nxt_pg_le = 1'b1, hi_pri_pend = 1'b0;
  logic exc_vld;
  logic [1:0] exc_cause;

  int total = 0;
  int bad = 0;
  logic       exp_vld = 1'b0;
  logic [1:0] exp_cause = 2'b00;

  always #5 clk = ~clk;

  fxp_checker #(.PAGE_BITS(PB), .INSN_BYTES(IB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_le(cfg_le), .fetch_vld(fetch_vld),
    .fetch_off(fetch_off), .user_mode(user_mode), .pg_ux(pg_ux), .pg_sx(pg_sx),
    .pg_le(pg_le), .nxt_pg_le(nxt_pg_le), .hi_pri_pend(hi_pri_pend),
    .exc_vld(exc_vld), .exc_cause(exc_cause)
  );

  // Reference: decides the outcome from the requirement text alone.
  task automatic model();
    int  off_i;
    bit  perm_ok, straddles, order_bad;
    off_i     = int'(fetch_off);
    perm_ok   = user_mode ? pg_ux : pg_sx;
    straddles = (off_i + IB) > (1 << PB);
    order_bad = (pg_le != cfg_le) || (straddles && nxt_pg_le != pg_le);
    exp_vld = 1'b0; exp_cause = 2'b00;
    if (fetch_vld && !hi_pri_pend) begin
      if (!perm_ok)       begin exp_vld = 1'b1; exp_cause = 2'b01; end
      else if (order_bad) begin exp_vld = 1'b1; exp_cause = 2'b10; end
    end
  endtask

  task automatic compare(string tag);
    total++;
    if (exc_vld !== exp_vld || exc_cause !== exp_cause) begin
      bad++;
      $display("FAIL %s: got vld=%b cause=%b, expected vld=%b cause=%b",
               tag, exc_vld, exc_cause, exp_vld, exp_cause);
    end
  endtask

  // Called at a falling edge: apply a vector, then check one cycle later.
  task automatic step(bit fv, int off, bit um, bit ux, bit sx, bit le, bit nle,
                      bit hp, string tag);
    fetch_vld = fv; fetch_off = PB'(off); user_mode = um; pg_ux = ux; pg_sx = sx;
    pg_le = le; nxt_pg_le = nle; hi_pri_pend = hp;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    cfg_le = 1'b1;
    step(1, 16, 1, 1, 0, 1, 1, 0, "R2 user ux=1 sx=0 passes");
    step(1, 16, 1, 0, 1, 1, 1, 0, "R2 user ux=0 faults");
    step(1, 20, 0, 0, 1, 1, 1, 0, "R3 sup sx=1 ux=0 passes");
    step(1, 20, 0, 1, 0, 1, 1, 0, "R3 sup sx=0 faults");
    step(1, 40, 0, 1, 1, 0, 0, 0, "R4 big page on little cfg");
    cfg_le = 1'b0;
    step(1, 40, 0, 1, 1, 0, 0, 0, "R4 big page on big cfg passes");
    step(1, 40, 1, 1, 1, 1, 1, 0, "R4 little page on big cfg");
    cfg_le = 1'b1;
    step(1, 4093, 0, 1, 1, 1, 0, 0, "R5 straddle with flip");
    step(1, 4092, 0, 1, 1, 1, 0, 0, "R5 last aligned slot ignores next page");
    step(1, 4095, 1, 1, 1, 1, 1, 0, "R5 straddle same order passes");
    step(1, 4094, 1, 0, 1, 0, 1, 0, "R6 exec beats order");
    step(1, 4094, 0, 1, 0, 1, 0, 0, "R6 exec beats straddle");
    step(1, 8, 1, 0, 0, 0, 1, 1, "R7 masked by higher priority");
    step(0, 4095, 1, 0, 0, 0, 1, 0, "R8 no strobe no fault");
    step(0, 8, 0, 0, 0, 0, 0, 0, "R8 cache-op style access ignored");
    // R9: output does not move before the capturing edge.
    fetch_vld = 1; user_mode = 1; pg_ux = 0; hi_pri_pend = 0;
    #1;
    total++;
    if (exc_vld !== 1'b0) begin
      bad++; $display("FAIL R9 early: got vld=%b, expected 0", exc_vld);
    end
    model();
    @(negedge clk);
    compare("R9 one cycle late");
    step(0, 0, 0, 1, 1, 1, 1, 0, "R9 clears after one cycle");

    for (int i = 0; i < 400; i++) begin
      if (i % 100 == 0) cfg_le = $urandom_range(0, 1);
      step($urandom_range(0, 3) != 0, ($urandom_range(0, 1) != 0) ? $urandom_range(4088, 4095)
                                                                  : $urandom_range(0, 4095),
           $urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
           ($urandom_range(0, 3) != 0) ? cfg_le : !cfg_le, $urandom_range(0, 1),
           $urandom_range(0, 5) == 0, "R9 random mix (R2-R8)");
    end

    rst_n = 1'b0;
    step(1, 8, 1, 0, 0, 0, 1, 0, "R1 reset mid-run");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // Reset overrides the model during the last vector.
  always @(rst_n) if (!rst_n) begin exp_vld = 1'b0; exp_cause = 2'b00; end
endmodule